// File: doc/BRIEF.md
# Buzzer Pair and Divided-Tone Pad Generator

This block makes audible and clock-like square waves for three push-pull port pads. A reloading up-counter starts at a preload value N and counts enabled clock cycles. When it reaches its top value it reloads N and flips a toggle flop. With the short (8-bit) count width, the toggle has a frequency of f/(2×(256−N)). With the wide (16-bit) width, 65536 takes the place of 256.

Three port data-register bits gate the toggle onto the pads. Bit 3 enables the divided-tone pad. Bit 0 and bit 1 together choose one of three drives for the buzzer pair: a complementary pair, a single buzzer line with its partner held low, or both lines forced low. A single toggle feeds both the tone pad and the buzzer pair.

When the timer is stopped, the counter sits at the preload and the toggle keeps its value. Enabling the timer therefore always begins a full period.

Top module: `tone_pad_gen`

## Requirements
- R1: After a synchronous active-low reset, the toggle is 0 and the counter holds the preload. With all data bits 0 this gives padA0=0, padA1=1 and padA3=0.
- R2: With wideSel=0 and timerOn=1, the toggle flips once every 256−N clock cycles, where N=preload[7:0]. The first flip comes 256−N cycles after enabling.
- R3: With wideSel=1 and timerOn=1, the toggle flips once every 65536−N clock cycles, where N=preload[15:0].
- R4: While timerOn=0, the toggle holds its value and the counter reloads N. Re-enabling gives a first flip exactly one full period later.
- R5: dataBit3=0 forces padA3=0 regardless of the timer.
- R6: dataBit3=1 makes padA3 equal to the toggle. It follows the divided signal while the timer runs and holds its last value while the timer is off.
- R7: dataBit0=0 with dataBit1=0 gives padA0 = toggle and padA1 = inverted toggle.
- R8: dataBit0=0 with dataBit1=1 gives padA0 = toggle and padA1 = 0.
- R9: dataBit0=1 forces padA0=0 and padA1=0, whatever dataBit1 is.
- R10: The preload is taken only at a reload. Changing it mid-period leaves the current period intact, and the new N sets the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock f |
| rstN | input | 1 | Synchronous active-low reset |
| timerOn | input | 1 | Timer run enable |
| wideSel | input | 1 | 1 selects 16-bit count width, 0 selects 8-bit |
| preload | input | 16 | Preload value N (low 8 bits used when wideSel=0) |
| dataBit0 | input | 1 | Port data-register bit 0 (buzzer mute) |
| dataBit1 | input | 1 | Port data-register bit 1 (complement line disable) |
| dataBit3 | input | 1 | Port data-register bit 3 (tone pad enable) |
| padA0 | output | 1 | Buzzer pad |
| padA1 | output | 1 | Complementary buzzer pad |
| padA3 | output | 1 | Divided-tone pad |

## Verification
The hardest situations to reach are the wide-width periods and a preload change inside a running period. The wide width needs tens of thousands of cycles before one flip shows at a pad. The preload case only shows up as a stretched or shortened half-period one reload later. The stimulus sweeps every 8-bit preload value and measures two consecutive half-periods at padA0 for each. It then runs a few wide preloads chosen so that each period stays within a few thousand cycles. It also rewrites the preload halfway through a measured half-period and checks both the current half-period and the following one.

// File: rtl/tone_pkg.sv
package tone_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic flip;
  } tone_strobe_t;
endpackage

// File: rtl/tone_ctrl.sv
module tone_ctrl (
  input  logic                  timerOn,
  input  logic                  atMax,
  output tone_pkg::tone_strobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (!timerOn) begin
      strobe.load = 1'b1;
    end else if (atMax) begin
      strobe.load = 1'b1;
      strobe.flip = 1'b1;
    end else begin
      strobe.step = 1'b1;
    end
  end
endmodule

// File: rtl/tone_dp.sv
module tone_dp #(
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wideSel,
  input  logic [CNT_W-1:0]      preload,
  input  logic                  dataBit0,
  input  logic                  dataBit1,
  input  logic                  dataBit3,
  input  tone_pkg::tone_strobe_t strobe,
  output logic                  atMax,
  output logic                  togQ,
  output logic                  padA0,
  output logic                  padA1,
  output logic                  padA3
);
  localparam logic [CNT_W-1:0]    WIDE_MAX   = '1;
  localparam logic [NARROW_W-1:0] NARROW_MAX = '1;

  logic [CNT_W-1:0]    cntQ;
  logic [CNT_W-1:0]    loadVal;
  logic [CNT_W-1:0]    incVal;
  logic [NARROW_W-1:0] narrowInc;

  generate
    if (NARROW_W < CNT_W) begin : g_ext
      assign loadVal = wideSel ? preload
                               : {{(CNT_W-NARROW_W){1'b0}}, preload[NARROW_W-1:0]};
      assign incVal  = wideSel ? cntQ + CNT_W'(1)
                               : {{(CNT_W-NARROW_W){1'b0}}, narrowInc};
    end else begin : g_same
      assign loadVal = preload;
      assign incVal  = cntQ + CNT_W'(1);
    end
  endgenerate

  assign narrowInc = cntQ[NARROW_W-1:0] + NARROW_W'(1);
  assign atMax = wideSel ? (cntQ == WIDE_MAX)
                         : (cntQ[NARROW_W-1:0] == NARROW_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= loadVal;
      togQ <= 1'b0;
    end else begin
      if (strobe.load)      cntQ <= loadVal;
      else if (strobe.step) cntQ <= incVal;
      if (strobe.flip)      togQ <= ~togQ;
    end
  end

  assign padA0 = !dataBit0 && togQ;
  assign padA1 = !dataBit0 && !dataBit1 && !togQ;
  assign padA3 = dataBit3 && togQ;
endmodule

// File: rtl/tone_pad_gen.sv
module tone_pad_gen #(
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             timerOn,
  input  logic             wideSel,
  input  logic [CNT_W-1:0] preload,
  input  logic             dataBit0,
  input  logic             dataBit1,
  input  logic             dataBit3,
  output logic             padA0,
  output logic             padA1,
  output logic             padA3
);
  tone_pkg::tone_strobe_t strobe;
  logic atMax;
  logic togQ;

  tone_ctrl ctrl_i (
    .timerOn(timerOn),
    .atMax  (atMax),
    .strobe (strobe)
  );

  tone_dp #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .wideSel (wideSel),
    .preload (preload),
    .dataBit0(dataBit0),
    .dataBit1(dataBit1),
    .dataBit3(dataBit3),
    .strobe  (strobe),
    .atMax   (atMax),
    .togQ    (togQ),
    .padA0   (padA0),
    .padA1   (padA1),
    .padA3   (padA3)
  );
endmodule

// File: rtl/tone_pad_gen_chk.sv
module tone_pad_gen_chk (
  input logic clk,
  input logic rstN,
  input logic timerOn,
  input logic dataBit0,
  input logic dataBit1,
  input logic dataBit3,
  input logic padA0,
  input logic padA1,
  input logic padA3,
  input logic togQ
);
  p_reset_clear_r1: assert property (@(posedge clk) !rstN |=> !togQ);
  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    !timerOn |=> $stable(togQ));
  p_tone_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    !dataBit3 |-> !padA3);
  p_tone_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    dataBit3 |-> (padA3 == togQ));
  p_pair_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!dataBit0 && !dataBit1) |-> (padA1 == !padA0) && (padA0 == togQ));
  p_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!dataBit0 && dataBit1) |-> !padA1 && (padA0 == togQ));
  p_muted_r9: assert property (@(posedge clk) disable iff (!rstN)
    dataBit0 |-> (!padA0 && !padA1));
endmodule

bind tone_pad_gen tone_pad_gen_chk chk_i (
  .clk(clk), .rstN(rstN), .timerOn(timerOn),
  .dataBit0(dataBit0), .dataBit1(dataBit1), .dataBit3(dataBit3),
  .padA0(padA0), .padA1(padA1), .padA3(padA3), .togQ(togQ)
);

// File: tb/tone_pad_gen_tb.sv
module tone_pad_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic timerOn = 1'b0;
  logic wideSel = 1'b0;
  logic [15:0] preload = '0;
  logic dataBit0 = 1'b0;
  logic dataBit1 = 1'b0;
  logic dataBit3 = 1'b0;
  logic padA0, padA1, padA3;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_pad_gen dut_i (
    .clk(clk), .rstN(rstN), .timerOn(timerOn), .wideSel(wideSel),
    .preload(preload), .dataBit0(dataBit0), .dataBit1(dataBit1),
    .dataBit3(dataBit3), .padA0(padA0), .padA1(padA1), .padA3(padA3)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count negedges until padA0 changes (requires dataBit0=0)
  task automatic measureHalf(input string req, input int exp);
    logic start;
    int n;
    start = padA0;
    n = 0;
    while (n < 70000) begin
      @(negedge clk);
      n++;
      if (padA0 != start) break;
    end
    check(req, n, exp);
  endtask

  task automatic restart(input logic wide, input int n);
    @(negedge clk);
    timerOn = 1'b0;
    wideSel = wide;
    preload = 16'(n);
    @(negedge clk);
    timerOn = 1'b1;
  endtask

  task automatic padsCheck(input logic tog);
    for (int k = 0; k < 8; k++) begin
      dataBit0 = k[0];
      dataBit1 = k[1];
      dataBit3 = k[2];
      #1;
      check("R9 R7 R8 padA0", padA0, (!k[0] && tog) ? 1 : 0);
      check("R9 R7 R8 padA1", padA1, (!k[0] && !k[1] && !tog) ? 1 : 0);
      check("R5 R6 padA3", padA3, (k[2] && tog) ? 1 : 0);
    end
    dataBit0 = 1'b0;
    dataBit1 = 1'b0;
    dataBit3 = 1'b0;
    #1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic held;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 padA0", padA0, 0);
    check("R1 padA1", padA1, 1);
    check("R1 padA3", padA3, 0);
    dataBit3 = 1'b1; #1;
    check("R1 padA3 gated on", padA3, 0);
    dataBit3 = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // R5 R7 R8 R9 with toggle low
    padsCheck(1'b0);

    // R2: sweep every 8-bit preload, two half periods each
    for (int n = 0; n < 256; n++) begin
      restart(1'b0, n);
      measureHalf("R2 first half", 256 - n);
      measureHalf("R2 second half", 256 - n);
    end
    // R2: upper preload bits ignored in narrow width
    restart(1'b0, 16'hAB00 + 16'd250);
    measureHalf("R2 upper bits ignored", 6);

    // toggle now known; pads with toggle high
    if (padA0 == 1'b0) begin
      restart(1'b0, 255);
      @(negedge clk);
    end
    timerOn = 1'b0;
    @(negedge clk);
    padsCheck(1'b1);

    // R3: wide width
    restart(1'b1, 65535);
    measureHalf("R3 N=65535", 1);
    restart(1'b1, 65000);
    measureHalf("R3 N=65000 first", 536);
    measureHalf("R3 N=65000 second", 536);
    restart(1'b1, 60000);
    measureHalf("R3 N=60000", 5536);

    // R4 R6: hold while off, then full period on re-enable
    restart(1'b0, 56);
    dataBit3 = 1'b1;
    repeat (90) @(negedge clk);
    timerOn = 1'b0;
    held = padA0;
    repeat (300) @(negedge clk);
    check("R4 hold padA0", padA0, held);
    check("R6 hold padA3", padA3, held);
    timerOn = 1'b1;
    measureHalf("R4 full period after re-enable", 200);
    check("R6 padA3 follows", padA3, padA0);
    dataBit3 = 1'b0; #1;
    check("R5 padA3 forced low", padA3, 0);

    // R10: preload changed mid-period
    restart(1'b0, 100);
    repeat (50) @(negedge clk);
    preload = 16'd200;
    measureHalf("R10 current period", 106);
    measureHalf("R10 next period", 56);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule